// File: doc/BRIEF.md
# Pull-Based Link Serializer Distributor

This block is the transmit side of a network interface on a spatially multiplexed on-chip network. A small set of 32-bit output queues feeds a larger set of single-wire links. Each link has its own serializer. A binding table, written through a plain configuration port when a connection is set up, ties each serializer to one queue. Several serializers may share one queue, and a serializer may also be left unbound.

Data moves on a pull basis. Each bound serializer with an empty shift register raises a request. A round-robin arbiter picks at most one request per cycle from those whose bound queue is offering a word. The winner's queue is popped, and the single shared distribution path steers the word to that serializer. The serializer then sends the word LSB first, one bit per cycle, with a valid flag beside the bit.

Each queue interface is valid/ready. A queue holds `q_valid` and its word until the block pops it. The block raises `q_ready[k]` only in a cycle where `q_valid[k]` is high, so `q_ready` depends combinationally on `q_valid`. A word is taken on a clock edge where both are high. The links carry no back-pressure: once a word starts, its 32 bits go out on consecutive cycles.

Top module: `sdm_tx_pull_ni`

## Requirements
- R1: After reset every serializer is unbound, every `link_vld` is low, and no `q_ready` is raised even when queues offer data.
- R2: A cycle with `cfg_we` high writes the entry of serializer `cfg_sid`. It becomes bound to queue `cfg_qid` when `cfg_en` is 1 and `cfg_qid` is below the queue count. Otherwise the entry is stored as unbound. The write takes effect from the next cycle.
- R3: An unbound serializer never causes a pop, and its link stays idle.
- R4: At most one `q_ready` bit is high per cycle. A high bit implies that the matching `q_valid` is high. A queue is popped only for a bound serializer whose shift register is empty.
- R5: A request to a queue whose `q_valid` is low is held without a pop. It is served once that queue offers data.
- R6: Contending requests are granted round-robin. The search starts at the serializer after the last one granted, and after reset serializer 0 has top priority.
- R7: A word popped on a clock edge appears on the granted serializer's link from the next cycle. `link_vld` is high for exactly 32 consecutive cycles, and in the j-th of these cycles `link_bit` carries bit j of the word (LSB first).
- R8: A serializer requests again only once its shift register is empty. When its queue keeps offering data, the first bit of its next word follows the last bit of the previous word after exactly one idle cycle.
- R9: Every popped word reaches exactly one serializer, and that serializer is bound to the queue the word came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Binding table write strobe |
| cfg_sid | input | 3 | Serializer whose entry is written |
| cfg_qid | input | 2 | Queue to bind that serializer to |
| cfg_en | input | 1 | 1 binds the entry, 0 unbinds it |
| q_valid | input | 3 | Per-queue word available |
| q_data | input | 96 | Per-queue word; queue k occupies bits [32k+31:32k] |
| q_ready | output | 3 | Per-queue pop, high only with the matching valid |
| link_bit | output | 8 | Serial data bit, one per link |
| link_vld | output | 8 | Serial bit valid, one per link |

## Verification
The bench builds the block with its defaults: eight links, three queues and 32-bit words. With three queues the 2-bit queue field can hold the value 3, which names no queue, so the R2 fallback to unbound can be reached from the ports. Each queue word carries its queue number, a sequence number and a checksum of that number. This lets every reassembled link word be traced back to one pop and to the binding in force. Several computed binding patterns are swept under full load, with some serializers unbound and some queues shared. Short directed phases pin down the round-robin order, the hold on an empty queue and the exact one-cycle gap.

// File: rtl/sdmtx_pkg.sv
package sdmtx_pkg;

  // Index width for a set of n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter that must reach n inclusive.
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sdmtx_bind_table.sv
module sdmtx_bind_table #(
  parameter int NSER = 8,
  parameter int NQ   = 3,
  parameter int SW   = 3,
  parameter int QW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SW-1:0]             cfg_sid,
  input  logic [QW-1:0]             cfg_qid,
  input  logic                      cfg_en,
  output logic [NSER-1:0]           bound,
  output logic [NSER-1:0][QW-1:0]   qsel
);

  logic qid_ok;
  assign qid_ok = (int'(cfg_qid) < NQ);

  for (genvar i = 0; i < NSER; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bound[i] <= 1'b0;
        qsel[i]  <= '0;
      end else if (cfg_we && (cfg_sid == SW'(i))) begin
        bound[i] <= cfg_en && qid_ok;
        qsel[i]  <= cfg_qid;
      end
    end
  end

endmodule

// File: rtl/sdmtx_rr_arb.sv
module sdmtx_rr_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [IW-1:0] last;
  int            cand;

  always_comb begin
    gnt  = '0;
    gidx = last;
    any  = 1'b0;
    cand = 0;
    for (int k = 1; k <= N; k++) begin
      cand = int'(last) + k;
      if (cand >= N) cand = cand - N;
      if (!any && req[cand]) begin
        any       = 1'b1;
        gnt[cand] = 1'b1;
        gidx      = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last <= IW'(N - 1);
    else if (any) last <= gidx;
  end

endmodule

// File: rtl/sdmtx_serializer.sv
module sdmtx_serializer #(
  parameter int DW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          idle,
  output logic          ser_bit,
  output logic          ser_vld
);

  logic [DW-1:0] shreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= din;
      left  <= CW'(DW);
    end else if (left != '0) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
    end
  end

  assign idle    = (left == '0);
  assign ser_vld = !idle;
  assign ser_bit = shreg[0];

endmodule

// File: rtl/sdm_tx_pull_ni.sv
module sdm_tx_pull_ni #(
  parameter  int NSER = 8,
  parameter  int NQ   = 3,
  parameter  int DW   = 32,
  localparam int SW   = sdmtx_pkg::idx_w(NSER),
  localparam int QW   = sdmtx_pkg::idx_w(NQ),
  localparam int CW   = sdmtx_pkg::cnt_w(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_sid,
  input  logic [QW-1:0]    cfg_qid,
  input  logic             cfg_en,
  input  logic [NQ-1:0]    q_valid,
  input  logic [NQ*DW-1:0] q_data,
  output logic [NQ-1:0]    q_ready,
  output logic [NSER-1:0]  link_bit,
  output logic [NSER-1:0]  link_vld
);

  logic [NSER-1:0]         bound;
  logic [NSER-1:0][QW-1:0] qsel;
  logic [NSER-1:0]         idle;
  logic [NSER-1:0]         req;
  logic [NSER-1:0]         gnt;
  logic [SW-1:0]           gidx;
  logic                    any_gnt;
  logic [QW-1:0]           pick_q;
  logic [DW-1:0]           pick_word;

  sdmtx_bind_table #(.NSER(NSER), .NQ(NQ), .SW(SW), .QW(QW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sid (cfg_sid),
    .cfg_qid (cfg_qid),
    .cfg_en  (cfg_en),
    .bound   (bound),
    .qsel    (qsel)
  );

  // A request is eligible only while its bound queue offers a word.
  always_comb begin
    for (int i = 0; i < NSER; i++) begin
      req[i] = 1'b0;
      for (int k = 0; k < NQ; k++) begin
        if (qsel[i] == QW'(k)) req[i] = bound[i] && idle[i] && q_valid[k];
      end
    end
  end

  sdmtx_rr_arb #(.N(NSER), .IW(SW)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt),
    .gidx  (gidx),
    .any   (any_gnt)
  );

  // Shared distributor: one queue read and one return path per cycle.
  always_comb begin
    pick_q    = qsel[gidx];
    pick_word = '0;
    for (int k = 0; k < NQ; k++) begin
      q_ready[k] = any_gnt && (pick_q == QW'(k));
      if (pick_q == QW'(k)) pick_word = q_data[k*DW +: DW];
    end
  end

  for (genvar i = 0; i < NSER; i++) begin : g_link
    sdmtx_serializer #(.DW(DW), .CW(CW)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gnt[i]),
      .din     (pick_word),
      .idle    (idle[i]),
      .ser_bit (link_bit[i]),
      .ser_vld (link_vld[i])
    );
  end

endmodule

// File: rtl/sdmtx_checker.sv
module sdmtx_checker #(
  parameter int NSER = 8,
  parameter int NQ   = 3,
  parameter int DW   = 32,
  parameter int SW   = 3,
  parameter int QW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [SW-1:0]   cfg_sid,
  input logic [QW-1:0]   cfg_qid,
  input logic            cfg_en,
  input logic [NQ-1:0]   q_valid,
  input logic [NQ-1:0]   q_ready,
  input logic [NSER-1:0] link_vld
);

  localparam int RW = sdmtx_pkg::cnt_w(DW);

  logic [NSER-1:0]         sh_en;
  logic [NSER-1:0][QW-1:0] sh_q;
  logic [NQ-1:0]           owner_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_en <= '0;
      sh_q  <= '0;
    end else if (cfg_we) begin
      sh_en[cfg_sid] <= cfg_en && (int'(cfg_qid) < NQ);
      sh_q[cfg_sid]  <= cfg_qid;
    end
  end

  always_comb begin
    for (int k = 0; k < NQ; k++) begin
      owner_ok[k] = 1'b0;
      for (int i = 0; i < NSER; i++) begin
        if (sh_en[i] && (sh_q[i] == QW'(k)) && !link_vld[i]) owner_ok[k] = 1'b1;
      end
    end
  end

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_ready)); // R4
  AST_POP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ready & ~q_valid) == '0); // R4
  AST_POP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ready & ~owner_ok) == '0); // R4

  for (genvar i = 0; i < NSER; i++) begin : g_run
    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
      if (!rst_n)           run <= '0;
      else if (link_vld[i]) run <= run + 1'b1;
      else                  run <= '0;
    end
    AST_RUN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      link_vld[i] |-> (run < RW'(DW))); // R7
    AST_RUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_vld[i]) |-> (run == RW'(DW))); // R7
    AST_UNBOUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_en[i] && !link_vld[i]) |=> !link_vld[i]); // R3
  end

endmodule

bind sdm_tx_pull_ni sdmtx_checker #(
  .NSER(NSER), .NQ(NQ), .DW(DW), .SW(SW), .QW(QW)
) u_sdmtx_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_sid  (cfg_sid),
  .cfg_qid  (cfg_qid),
  .cfg_en   (cfg_en),
  .q_valid  (q_valid),
  .q_ready  (q_ready),
  .link_vld (link_vld)
);

// File: tb/tb_sdm_tx_pull_ni.sv
`timescale 1ns/1ps
module tb_sdm_tx_pull_ni;

  localparam int NSER = 8;
  localparam int NQ   = 3;
  localparam int DW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_sid = '0;
  logic [1:0]      cfg_qid = '0;
  logic            cfg_en = 1'b0;
  logic [NQ-1:0]   q_valid;
  logic [NQ*DW-1:0] q_data;
  logic [NQ-1:0]   q_ready;
  logic [NSER-1:0] link_bit;
  logic [NSER-1:0] link_vld;

  sdm_tx_pull_ni #(.NSER(NSER), .NQ(NQ), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sid(cfg_sid),
    .cfg_qid(cfg_qid), .cfg_en(cfg_en), .q_valid(q_valid), .q_data(q_data),
    .q_ready(q_ready), .link_bit(link_bit), .link_vld(link_vld)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int cyc = 0;
  int avail [NQ];
  int seq [NQ];
  int ndel_q [NQ];
  int pop_cyc [NQ];
  bit got [NQ][4096];
  int bmap [NSER];
  logic [DW-1:0] acc [NSER];
  int lcnt [NSER];
  int ndel [NSER];
  int last_seq [NSER];
  int last_end [NSER];
  int gap_last [NSER];
  int lat_last [NSER];
  int snap [NSER];

  function automatic logic [DW-1:0] mkw(input int k, input int n);
    logic [15:0] h;
    h = 16'(n * 40503) ^ 16'hA5C3;
    return {4'(k), 12'(n), h};
  endfunction

  task automatic chk(input bit ok, input string req, input string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // Queue model, pop monitor and link reassembly.
  always @(negedge clk) begin
    for (int k = 0; k < NQ; k++) begin
      q_valid[k] = (avail[k] > 0);
      q_data[k*DW +: DW] = mkw(k, seq[k]);
    end
    #2;
    if (rst_n) begin
      cyc++;
      if ($countones(q_ready) > 1)
        chk(0, "R4", $sformatf("q_ready=%b expected at most one bit", q_ready));
      for (int k = 0; k < NQ; k++) begin
        if (q_ready[k] && !q_valid[k])
          chk(0, "R4", $sformatf("q_ready[%0d]=1 with q_valid=0, expected 0", k));
        if (q_ready[k] && q_valid[k]) begin
          bit owned = 0;
          for (int i = 0; i < NSER; i++) if (bmap[i] == k) owned = 1;
          if (!owned) chk(0, "R3", $sformatf("pop of queue %0d with no bound serializer, expected none", k));
          seq[k]++;
          avail[k]--;
          pop_cyc[k] = cyc;
        end
      end
      for (int i = 0; i < NSER; i++) begin
        if (link_vld[i]) begin
          if (lcnt[i] == 0) begin
            gap_last[i] = cyc - last_end[i];
            lat_last[i] = (bmap[i] >= 0) ? cyc - pop_cyc[bmap[i]] : -1;
          end
          acc[i][lcnt[i]] = link_bit[i];
          lcnt[i]++;
          if (lcnt[i] == DW) begin
            int wk, wn;
            wk = int'(acc[i][31:28]);
            wn = int'(acc[i][27:16]);
            chk(acc[i] == mkw(wk, wn), "R7",
                $sformatf("link %0d word %h, expected %h", i, acc[i], mkw(wk, wn)));
            chk(wk == bmap[i], "R9", $sformatf("link %0d word from queue %0d, expected %0d", i, wk, bmap[i]));
            if (wk < NQ) begin
              chk(wn < seq[wk] && !got[wk][wn], "R9",
                  $sformatf("link %0d seq %0d dup=%0d popped=%0d, expected fresh popped word", i, wn, got[wk][wn], seq[wk]));
              got[wk][wn] = 1;
              ndel_q[wk]++;
            end
            ndel[i]++;
            last_seq[i] = wn;
            last_end[i] = cyc;
            lcnt[i] = 0;
          end
        end else if (lcnt[i] != 0) begin
          chk(0, "R7", $sformatf("link %0d valid dropped after %0d bits, expected %0d", i, lcnt[i], DW));
          lcnt[i] = 0;
        end
      end
    end
  end

  task automatic cfg(input int s, input int q, input bit en);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sid = 3'(s); cfg_qid = 2'(q); cfg_en = en;
    bmap[s] = (en && q < NQ) ? q : -1;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic set_avail(input int k, input int v);
    @(posedge clk); #1;
    avail[k] = v;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NQ; k++) begin
      avail[k] = 5; seq[k] = 0; ndel_q[k] = 0; pop_cyc[k] = 0;
    end
    for (int i = 0; i < NSER; i++) begin
      bmap[i] = -1; lcnt[i] = 0; ndel[i] = 0; last_seq[i] = -1;
      last_end[i] = 0; gap_last[i] = 0; lat_last[i] = 0; acc[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state, queues offering data, nothing bound.
    @(negedge clk); #1;
    chk(link_vld == '0 && q_ready == '0, "R1",
        $sformatf("link_vld=%b q_ready=%b, expected 0/0", link_vld, q_ready));
    idle_cycles(20);
    chk(seq[0] + seq[1] + seq[2] == 0, "R1",
        $sformatf("pops after reset=%0d, expected 0", seq[0] + seq[1] + seq[2]));
    for (int k = 0; k < NQ; k++) set_avail(k, 0);

    // R6: serializers 2 and 5 share queue 0.
    cfg(2, 0, 1);
    cfg(5, 0, 1);
    set_avail(0, 1);
    idle_cycles(40);
    chk(ndel[2] == 1 && last_seq[2] == 0 && ndel[5] == 0, "R6",
        $sformatf("first grant: link2 n=%0d seq=%0d link5 n=%0d, expected 1/0/0", ndel[2], last_seq[2], ndel[5]));
    set_avail(0, 1);
    idle_cycles(40);
    chk(ndel[5] == 1 && last_seq[5] == 1 && ndel[2] == 1, "R6",
        $sformatf("second grant: link5 n=%0d seq=%0d link2 n=%0d, expected 1/1/1", ndel[5], last_seq[5], ndel[2]));

    // R5, R7, R8: serializer 7 on an empty queue 2.
    cfg(2, 0, 0);
    cfg(5, 0, 0);
    cfg(7, 2, 1);
    idle_cycles(50);
    chk(ndel[7] == 0 && seq[2] == 0 && link_vld[7] == 1'b0, "R5",
        $sformatf("empty queue: link7 words=%0d pops=%0d, expected 0/0", ndel[7], seq[2]));
    set_avail(2, 2);
    idle_cycles(80);
    chk(ndel[7] == 2, "R5", $sformatf("held request served: words=%0d, expected 2", ndel[7]));
    chk(lat_last[7] == 1, "R7", $sformatf("pop to first bit=%0d cycles, expected 1", lat_last[7]));
    chk(gap_last[7] == 2, "R8", $sformatf("last bit to next first bit=%0d cycles, expected 2", gap_last[7]));

    // R2: queue number 3 names no queue, entry stays unbound.
    cfg(3, 3, 1);
    set_avail(0, 3);
    idle_cycles(50);
    chk(ndel[3] == 0 && seq[0] == 2, "R2",
        $sformatf("out-of-range bind: link3 words=%0d q0 pops=%0d, expected 0/2", ndel[3], seq[0]));
    set_avail(0, 0);

    // R3, R9: computed binding sweep under full load.
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < NSER; s++)
        cfg(s, (s + p) % NQ, ((s + 2 * p) % 7) != 0);
      for (int s = 0; s < NSER; s++) snap[s] = ndel[s];
      for (int k = 0; k < NQ; k++) set_avail(k, 1000);
      idle_cycles(300);
      for (int k = 0; k < NQ; k++) set_avail(k, 0);
      idle_cycles(40);
      for (int s = 0; s < NSER; s++) begin
        if (bmap[s] < 0)
          chk(ndel[s] == snap[s], "R3",
              $sformatf("pattern %0d unbound link %0d sent %0d words, expected 0", p, s, ndel[s] - snap[s]));
        else
          chk(ndel[s] - snap[s] >= 8, "R9",
              $sformatf("pattern %0d bound link %0d sent %0d words, expected at least 8", p, s, ndel[s] - snap[s]));
      end
      for (int k = 0; k < NQ; k++)
        chk(ndel_q[k] == seq[k], "R9",
            $sformatf("pattern %0d queue %0d delivered %0d, expected %0d", p, k, ndel_q[k], seq[k]));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule